// File: doc/BRIEF.md
# Global Register Write Broadcaster

Each cluster of a multithreaded processor holds its own mirror of every global register. This block is one cluster's mirror together with its outgoing write queue. A thread that writes a global register updates the local mirror at once. The same write is also placed in a small queue. Queued writes go out, oldest first, on a bus that is shared with prefix-sum results. They use only the cycles in which no prefix-sum result is on the bus and the cluster holds the bus grant. Every cluster snoops that bus and copies broadcasts from other clusters into its own mirror, so the last broadcast of a register ends up in every copy.

Mirrors may be stale for a while. Synchronisation happens only at two points, and both wait for this cluster's queue to be empty: a gatekeeper prefix-sum request is passed on only then, and a join is reported complete only then. A write accepted in the same cycle also holds both back. The queue occupancy is tracked by a three-state machine:

- QS_EMPTY: no pending writes.
- QS_PARTIAL: at least one pending write and spare room.
- QS_FULL: no room left.

The transitions are named as follows:

- EMPTY→PARTIAL on a push.
- PARTIAL→EMPTY when the last entry is popped.
- PARTIAL→FULL when the last free slot is filled.
- FULL→PARTIAL on a pop.
- Every state holds when there is no net change.

Top module: `greg_bcast`

## Requirements
- R1: After reset all mirror registers read 0, `drained` is 1, `bus_valid` is 0 and `wr_ready` is 1.
- R2: A write with `wr_valid`=1 and `wr_ready`=1 is stored into the local mirror at the clock edge, so that `rd_data` shows it from the next cycle on. It is also appended to the queue.
- R3: The queue holds 4 entries. While 4 are pending, `wr_ready` is 0, and a write offered then changes neither the mirror nor the queue.
- R4: `bus_valid` is 1 exactly when the queue is non-empty, `ps_active` is 0 and `bus_grant` is 1. When it is 1, the oldest entry is driven on `bus_id`/`bus_data` and removed at the clock edge. Entries leave in the order they were accepted.
- R5: While `bus_valid` is 1, `bus_src` equals the cluster number. While `bus_valid` is 0, `bus_id` and `bus_data` are 0.
- R6: A snooped broadcast (`snoop_valid`=1) whose `snoop_src` differs from the cluster number writes `snoop_data` into mirror register `snoop_id`. A broadcast carrying the cluster's own number is ignored.
- R7: If a local write and a foreign snoop target the same register in one cycle, the local value is kept, because its own broadcast will come later on the bus.
- R8: `drained` is 1 exactly when the queue is empty.
- R9: `gk_issue` is 1 exactly when `gk_req` is 1, the queue is empty and `wr_valid` is 0.
- R10: `join_ok` is 1 exactly when `join_req` is 1, the queue is empty and `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Local thread writes a global register |
| wr_id | input | 3 | Register number of the local write |
| wr_data | input | 16 | Value of the local write |
| wr_ready | output | 1 | Write accepted this cycle; 0 stalls the thread |
| rd_id | input | 3 | Mirror read address |
| rd_data | output | 16 | Mirror contents at `rd_id` |
| ps_active | input | 1 | A prefix-sum result occupies the bus this cycle |
| bus_grant | input | 1 | This cluster may use a free bus cycle |
| bus_valid | output | 1 | Broadcast driven this cycle |
| bus_src | output | 2 | Cluster number of the broadcast |
| bus_id | output | 3 | Register number broadcast |
| bus_data | output | 16 | Value broadcast |
| snoop_valid | input | 1 | A register broadcast is seen on the bus |
| snoop_src | input | 2 | Originating cluster of the snooped broadcast |
| snoop_id | input | 3 | Register number snooped |
| snoop_data | input | 16 | Value snooped |
| drained | output | 1 | No write pending in the queue |
| gk_req | input | 1 | Thread asks to issue a gatekeeper prefix-sum |
| gk_issue | output | 1 | Gatekeeper request may leave now |
| join_req | input | 1 | Join is waiting to complete |
| join_ok | output | 1 | Join may complete now |

## Verification
The bench targets a full queue with the bus withheld, then offers a fifth write to a fresh register. A design that overwrote an entry or stored the rejected value in the mirror would show the wrong value on a later read or broadcast. It collides a local write with a foreign snoop to the same register. It also sends snoops that carry the cluster's own number; a design that applied them would let a stale broadcast overwrite a newer local value. Prefix-sum cycles are interleaved with pending writes, so that a design transmitting under `ps_active`, or losing order across a stalled cycle, sends the wrong head. Gatekeeper and join requests arrive with one entry left and in the cycle of a fresh write, which catches a drain status that is one cycle early.

// File: rtl/greg_pkg.sv
package greg_pkg;
    typedef enum logic [1:0] {
        QS_EMPTY   = 2'd0,
        QS_PARTIAL = 2'd1,
        QS_FULL    = 2'd2
    } qstate_e;
endpackage

// File: rtl/greg_qctl.sv
module greg_qctl
    import greg_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_req,
    input  logic    pop_req,
    output logic    push_ok,
    output logic    pop_ok,
    output logic    empty,
    output logic    full,
    output qstate_e state
);
    localparam int CW = $clog2(DEPTH + 1);

    qstate_e       state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QS_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // outputs per state
    always_comb begin
        empty   = 1'b0;
        full    = 1'b0;
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state_q)
            QS_EMPTY: begin
                empty   = 1'b1;
                push_ok = push_req;
            end
            QS_PARTIAL: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            QS_FULL: begin
                full   = 1'b1;
                pop_ok = pop_req;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
    end

    // next state
    always_comb begin
        count_d = count_q + CW'(push_ok) - CW'(pop_ok);
        state_d = state_q;
        unique case (state_q)
            QS_EMPTY:   if (push_ok) state_d = QS_PARTIAL;
            QS_PARTIAL: begin
                if (count_d == '0)            state_d = QS_EMPTY;
                else if (count_d == CW'(DEPTH)) state_d = QS_FULL;
            end
            QS_FULL:    if (pop_ok) state_d = QS_PARTIAL;
            default:    state_d = QS_EMPTY;
        endcase
    end

    assign state = state_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_ok); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_req) |=> full); // R3
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop_ok); // R4
endmodule

// File: rtl/greg_wfifo.sv
module greg_wfifo #(
    parameter int DEPTH = 4,
    parameter int W     = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                         slots[g] <= '0;
            else if (push && wr_ptr == PW'(g))  slots[g] <= din;
        end
    end

    assign dout = slots[rd_ptr];
endmodule

// File: rtl/greg_mirror.sv
module greg_mirror #(
    parameter int NREG       = 8,
    parameter int DW         = 16,
    parameter int IDW        = 3,
    parameter int SW         = 2,
    parameter int CLUSTER_ID = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lw_en,
    input  logic [IDW-1:0] lw_id,
    input  logic [DW-1:0]  lw_data,
    input  logic           sn_valid,
    input  logic [SW-1:0]  sn_src,
    input  logic [IDW-1:0] sn_id,
    input  logic [DW-1:0]  sn_data,
    input  logic [IDW-1:0] rd_id,
    output logic [DW-1:0]  rd_data
);
    logic [DW-1:0] regs [NREG];
    logic          sn_foreign;

    assign sn_foreign = sn_valid && (sn_src != SW'(CLUSTER_ID));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (lw_en && lw_id == IDW'(g))
                regs[g] <= lw_data;
            else if (sn_foreign && sn_id == IDW'(g))
                regs[g] <= sn_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_id) < NREG) rd_data = regs[rd_id];
    end

    AST_SNOOP_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_foreign && !(lw_en && lw_id == sn_id))
        |=> regs[$past(sn_id)] == $past(sn_data)); // R6
    AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en |=> regs[$past(lw_id)] == $past(lw_data)); // R7
endmodule

// File: rtl/greg_bcast.sv
module greg_bcast
    import greg_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int DW         = 16,
    parameter int DEPTH      = 4,
    parameter int NCLUST     = 4,
    parameter int CLUSTER_ID = 0,
    localparam int IDW = $clog2(NREG),
    localparam int SW  = $clog2(NCLUST)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_valid,
    input  logic [IDW-1:0] wr_id,
    input  logic [DW-1:0]  wr_data,
    output logic           wr_ready,
    input  logic [IDW-1:0] rd_id,
    output logic [DW-1:0]  rd_data,
    input  logic           ps_active,
    input  logic           bus_grant,
    output logic           bus_valid,
    output logic [SW-1:0]  bus_src,
    output logic [IDW-1:0] bus_id,
    output logic [DW-1:0]  bus_data,
    input  logic           snoop_valid,
    input  logic [SW-1:0]  snoop_src,
    input  logic [IDW-1:0] snoop_id,
    input  logic [DW-1:0]  snoop_data,
    output logic           drained,
    input  logic           gk_req,
    output logic           gk_issue,
    input  logic           join_req,
    output logic           join_ok
);
    localparam int EW = IDW + DW;

    logic          push_ok, pop_ok, q_empty, q_full;
    logic          slot_free;
    qstate_e       q_state;
    logic [EW-1:0] head;

    assign slot_free = !ps_active && bus_grant;

    greg_qctl #(.DEPTH(DEPTH)) u_qctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .pop_req  (slot_free),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .empty    (q_empty),
        .full     (q_full),
        .state    (q_state)
    );

    greg_wfifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .pop   (pop_ok),
        .din   ({wr_id, wr_data}),
        .dout  (head)
    );

    greg_mirror #(
        .NREG(NREG), .DW(DW), .IDW(IDW), .SW(SW), .CLUSTER_ID(CLUSTER_ID)
    ) u_mirror (
        .clk      (clk),
        .rst_n    (rst_n),
        .lw_en    (push_ok),
        .lw_id    (wr_id),
        .lw_data  (wr_data),
        .sn_valid (snoop_valid),
        .sn_src   (snoop_src),
        .sn_id    (snoop_id),
        .sn_data  (snoop_data),
        .rd_id    (rd_id),
        .rd_data  (rd_data)
    );

    always_comb begin
        wr_ready  = !q_full;
        bus_valid = pop_ok;
        bus_src   = SW'(CLUSTER_ID);
        bus_id    = '0;
        bus_data  = '0;
        if (pop_ok) begin
            bus_id   = head[EW-1:DW];
            bus_data = head[DW-1:0];
        end
        drained  = q_empty;
        gk_issue = gk_req   && q_empty && !wr_valid;
        join_ok  = join_req && q_empty && !wr_valid;
    end

    AST_PS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ps_active |-> !bus_valid); // R4
    AST_GK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        gk_issue |-> (drained && q_state == QS_EMPTY)); // R9
    AST_JOIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        join_ok |-> drained); // R10
    AST_WRITE_UNDRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !bus_valid) |=> !drained); // R8
endmodule

// File: tb/tb_greg_bcast.sv
module tb_greg_bcast;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_id = '0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic [2:0]  rd_id = '0;
    logic [15:0] rd_data;
    logic        ps_active = 1'b0, bus_grant = 1'b0;
    logic        bus_valid;
    logic [1:0]  bus_src;
    logic [2:0]  bus_id;
    logic [15:0] bus_data;
    logic        snoop_valid = 1'b0;
    logic [1:0]  snoop_src = '0;
    logic [2:0]  snoop_id = '0;
    logic [15:0] snoop_data = '0;
    logic        drained, gk_req = 1'b0, gk_issue, join_req = 1'b0, join_ok;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [2:0]  m_qid [4];
    logic [15:0] m_qd  [4];
    int          m_n = 0;
    logic [15:0] m_mir [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    greg_bcast dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_id(rd_id), .rd_data(rd_data),
        .ps_active(ps_active), .bus_grant(bus_grant),
        .bus_valid(bus_valid), .bus_src(bus_src), .bus_id(bus_id), .bus_data(bus_data),
        .snoop_valid(snoop_valid), .snoop_src(snoop_src), .snoop_id(snoop_id),
        .snoop_data(snoop_data),
        .drained(drained), .gk_req(gk_req), .gk_issue(gk_issue),
        .join_req(join_req), .join_ok(join_ok)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic wv, input logic [2:0] wid, input logic [15:0] wd,
                       input logic [2:0] rid, input logic ps, input logic gr,
                       input logic sv, input logic [1:0] ss, input logic [2:0] sid,
                       input logic [15:0] sd, input logic gk, input logic jr);
        logic e_bv;
        logic e_acc;
        @(negedge clk);
        wr_valid = wv; wr_id = wid; wr_data = wd; rd_id = rid;
        ps_active = ps; bus_grant = gr;
        snoop_valid = sv; snoop_src = ss; snoop_id = sid; snoop_data = sd;
        gk_req = gk; join_req = jr;
        #1;
        e_bv  = (m_n > 0) && !ps && gr;
        e_acc = wv && (m_n < 4);
        chk("R3 wr_ready", int'(wr_ready), int'(m_n < 4));
        chk("R2/R6/R7 rd_data", int'(rd_data), int'(m_mir[rid]));
        chk("R4 bus_valid", int'(bus_valid), int'(e_bv));
        chk("R4/R5 bus_id", int'(bus_id), e_bv ? int'(m_qid[0]) : 0);
        chk("R4/R5 bus_data", int'(bus_data), e_bv ? int'(m_qd[0]) : 0);
        if (e_bv) chk("R5 bus_src", int'(bus_src), 0);
        chk("R8 drained", int'(drained), int'(m_n == 0));
        chk("R9 gk_issue", int'(gk_issue), int'(gk && m_n == 0 && !wv));
        chk("R10 join_ok", int'(join_ok), int'(jr && m_n == 0 && !wv));
        // model update at the coming edge
        if (e_bv) begin
            for (int i = 0; i < 3; i++) begin
                m_qid[i] = m_qid[i+1];
                m_qd[i]  = m_qd[i+1];
            end
            m_n--;
        end
        if (sv && ss != 2'd0) m_mir[sid] = sd;
        if (e_acc) begin
            m_mir[wid] = wd;
            m_qid[m_n] = wid;
            m_qd[m_n]  = wd;
            m_n++;
        end
    endtask

    task automatic idle(input logic [2:0] rid);
        cyc(1'b0, 3'd0, 16'd0, rid, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (NCYC * 4 + 500) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) m_mir[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every mirror register reads zero
        for (int r = 0; r < 8; r++) idle(3'(r));
        chk("R1 drained after reset", int'(drained), 1);

        // R2: write then read back; R9/R10 held in the write cycle
        cyc(1'b1, 3'd2, 16'h1234, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b1, 1'b1);
        idle(3'd2);

        // R3: fill to four with the bus withheld, then a rejected fifth write
        cyc(1'b1, 3'd3, 16'h0003, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b0, 1'b0);
        cyc(1'b1, 3'd4, 16'h0004, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b0, 1'b0);
        cyc(1'b1, 3'd5, 16'h0005, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b0, 1'b0);
        cyc(1'b1, 3'd7, 16'hABCD, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, 1'b1, 1'b1);
        idle(3'd7);

        // R4: prefix-sum traffic blocks the bus even with the grant held
        cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0, 1'b0, 1'b0);
        // R4: drain in order, with gatekeeper and join asked on the way
        for (int k = 0; k < 5; k++)
            cyc(1'b0, 3'd0, 16'd0, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0, 1'b1, 1'b1);

        // R6: own-number snoop ignored, foreign snoop applied
        cyc(1'b0, 3'd0, 16'd0, 3'd6, 1'b0, 1'b0, 1'b1, 2'd0, 3'd6, 16'hDEAD, 1'b0, 1'b0);
        cyc(1'b0, 3'd0, 16'd0, 3'd6, 1'b0, 1'b0, 1'b1, 2'd3, 3'd6, 16'hBEEF, 1'b0, 1'b0);
        idle(3'd6);

        // R7: local write and foreign snoop to the same register in one cycle
        cyc(1'b1, 3'd1, 16'h5555, 3'd1, 1'b0, 1'b0, 1'b1, 2'd2, 3'd1, 16'hAAAA, 1'b0, 1'b0);
        idle(3'd1);

        // random mix
        for (int c = 0; c < NCYC; c++) begin
            cyc(1'(($urandom % 3) == 0), 3'($urandom), 16'($urandom), 3'($urandom),
                1'(($urandom % 4) == 0), 1'(($urandom % 3) != 0),
                1'(($urandom % 3) == 0), 2'($urandom), 3'($urandom), 16'($urandom),
                1'(($urandom % 4) == 0), 1'(($urandom % 5) == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule